// File: doc/BRIEF.md
# Store Buffer with Load Forwarding Checks

This block keeps stores that have executed but not yet been written to the data cache. Stores enter in program order and wait in a small circular queue. A store may leave only after the surrounding pipeline signals that it has retired. Retired stores are written to the cache write port one per cycle, oldest first.

Every load is checked against the stores still held in the queue, and the block gives one of three answers. If no held store touches any byte the load reads, the answer is a miss and the load reads the cache. If the youngest store that touches the load is able to supply the data, the answer is a forward and the data is returned. In every other case the answer is a stall, and the load has to be retried after that store has drained.

A store can supply a load only when all of these hold:
- both accesses start at the same address;
- the load is no wider than the store;
- neither access is misaligned;
- the store's data was not taken from the upper byte of a register.

Top module: `store_fwd_buffer`

## Requirements
- R1: The queue holds DEPTH (default 8) stores in arrival order. `enq_full` is 1 exactly when DEPTH stores are held. An enqueue presented while `enq_full` is 1 is dropped, even if a drain happens in the same cycle.
- R2: A `ret_strobe` pulse marks the oldest store that is not yet retired as retired. A pulse is ignored when every held store is already retired or when the queue is empty.
- R3: In each cycle where the oldest held store is retired, that store is removed. One cycle later `cw_valid` is 1 and `cw_addr`, `cw_size` and `cw_data` carry that store. Stores drain in arrival order, at most one per cycle.
- R4: A load is presented with `ld_valid`. The answer appears one cycle later with `rsp_valid`=1 and `rsp_kind` set to 0 for a miss, 1 for a forward or 2 for a stall. The answer reflects the stores held before the edge at which the load was sampled. A load whose byte range meets no held store is a miss with `rsp_data`=0.
- R5: Sizes are encoded in 2 bits: 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. A forward returns the low 2^size bytes of the store data, with the upper bytes zero, and happens only when all four conditions listed above hold.
- R6: When several held stores overlap a load, only the youngest of them is evaluated. Older stores never decide the answer.
- R7: A load that overlaps the youngest store but fails a forwarding condition stalls. This includes a narrower store lying inside a wider load. Once that store has drained, the same load no longer sees it.
- R8: An access is misaligned when its address is not a multiple of its size. A store is also treated as misaligned when `enq_misflag` was 1 at enqueue. Store data from the upper byte of a register is marked by `enq_hibyte`=1, and such data is never forwarded.
- R9: After synchronous reset the queue is empty, and `enq_full`, `rsp_valid` and `cw_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Enqueue a store this cycle |
| enq_addr | input | AW | Store start byte address |
| enq_size | input | 2 | Store size code |
| enq_data | input | 64 | Store data, low bytes significant |
| enq_hibyte | input | 1 | Data came from the upper byte of a register |
| enq_misflag | input | 1 | Store flagged as misaligned |
| enq_full | output | 1 | Queue holds DEPTH stores |
| ret_strobe | input | 1 | Retire the oldest store not yet retired |
| ld_valid | input | 1 | Load query valid |
| ld_addr | input | AW | Load start byte address |
| ld_size | input | 2 | Load size code |
| rsp_valid | output | 1 | Answer valid |
| rsp_kind | output | 2 | 0 miss, 1 forward, 2 stall |
| rsp_data | output | 64 | Forwarded data, zero-extended |
| cw_valid | output | 1 | Cache write valid |
| cw_addr | output | AW | Cache write address |
| cw_size | output | 2 | Cache write size code |
| cw_data | output | 64 | Cache write data |

## Verification
If the head, tail or retire count goes wrong, the ports show it at the next drain. The cache write port then carries a store out of order, carries it too early, or emits an extra write. The bench checks the exact cycle of every drain relative to its retire pulse. A wrong valid bit or age scan shows up one cycle after the next load: that load returns the wrong answer kind or stale data. The sweep over load offsets and sizes around each store size and flag setting is designed to expose such faults quickly.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

  localparam int DW = 64;

  typedef enum logic [1:0] {
    RSP_MISS  = 2'd0,
    RSP_FWD   = 2'd1,
    RSP_STALL = 2'd2
  } rsp_kind_e;

  // byte count for a 2-bit size code
  function automatic logic [3:0] size_bytes(input logic [1:0] s);
    return 4'd1 << s;
  endfunction

  // address low bits not a multiple of the size
  function automatic logic is_misaligned(input logic [2:0] lo, input logic [1:0] s);
    case (s)
      2'd0:    return 1'b0;
      2'd1:    return lo[0];
      2'd2:    return |lo[1:0];
      default: return |lo[2:0];
    endcase
  endfunction

  // mask covering the low bytes of an access of the given size
  function automatic logic [DW-1:0] low_mask(input logic [1:0] s);
    case (s)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/sfb_queue.sv
module sfb_queue
  import sfb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        enq_valid,
  input  logic [AW-1:0]               enq_addr,
  input  logic [1:0]                  enq_size,
  input  logic [DW-1:0]               enq_data,
  input  logic                        enq_hibyte,
  input  logic                        enq_misflag,
  output logic                        enq_full,
  input  logic                        ret_strobe,
  output logic [DEPTH-1:0]            e_vld,
  output logic [DEPTH-1:0][AW-1:0]    e_addr,
  output logic [DEPTH-1:0][1:0]       e_size,
  output logic [DEPTH-1:0][DW-1:0]    e_data,
  output logic [DEPTH-1:0]            e_block,
  output logic [$clog2(DEPTH)-1:0]    head_idx,
  output logic                        cw_valid,
  output logic [AW-1:0]               cw_addr,
  output logic [1:0]                  cw_size,
  output logic [DW-1:0]               cw_data
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] count, rcnt;
  logic do_enq, do_ret, do_drain, enq_bad;

  assign do_enq   = enq_valid && (count != FULL_CNT);
  assign do_ret   = ret_strobe && (rcnt != count);
  assign do_drain = (rcnt != '0);
  assign enq_full = (count == FULL_CNT);
  assign head_idx = head;
  // misaligned by address, or flagged by the producer, or high-byte source
  assign enq_bad  = enq_misflag || enq_hibyte ||
                    is_misaligned(enq_addr[2:0], enq_size);

  // payload storage, no reset so it maps to plain memory bits
  always_ff @(posedge clk) begin
    if (do_enq) begin
      e_addr[tail]  <= enq_addr;
      e_size[tail]  <= enq_size;
      e_data[tail]  <= enq_data;
      e_block[tail] <= enq_bad;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head     <= '0;
      tail     <= '0;
      count    <= '0;
      rcnt     <= '0;
      e_vld    <= '0;
      cw_valid <= 1'b0;
      cw_addr  <= '0;
      cw_size  <= '0;
      cw_data  <= '0;
    end else begin
      cw_valid <= do_drain;
      if (do_drain) begin
        cw_addr <= e_addr[head];
        cw_size <= e_size[head];
        cw_data <= e_data[head];
        head    <= head + 1'b1;
      end
      if (do_enq) tail <= tail + 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        if (do_enq && (tail == PTR_W'(i)))
          e_vld[i] <= 1'b1;
        else if (do_drain && (head == PTR_W'(i)))
          e_vld[i] <= 1'b0;
      end
      count <= count + CNT_W'(do_enq) - CNT_W'(do_drain);
      rcnt  <= rcnt + CNT_W'(do_ret) - CNT_W'(do_drain);
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R2
  retire_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rcnt <= count);

  // R3
  drain_after_retire_chk: assert property (@(posedge clk) disable iff (rst)
    cw_valid |-> ($past(rcnt) != '0));

  // R1
  valid_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(e_vld) == int'(count));

endmodule

// File: rtl/sfb_match.sv
module sfb_match
  import sfb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16
) (
  input  logic [AW-1:0]               ld_addr,
  input  logic [1:0]                  ld_size,
  input  logic [DEPTH-1:0]            e_vld,
  input  logic [DEPTH-1:0][AW-1:0]    e_addr,
  input  logic [DEPTH-1:0][1:0]       e_size,
  input  logic [DEPTH-1:0][DW-1:0]    e_data,
  input  logic [DEPTH-1:0]            e_block,
  input  logic [$clog2(DEPTH)-1:0]    head_idx,
  output rsp_kind_e                   m_kind,
  output logic [DW-1:0]               m_data
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0] ovl;
  logic [AW:0]      ld_end;
  logic             hit, ld_mis, ok;
  logic [PTR_W-1:0] sel, idx;

  assign ld_end = {1'b0, ld_addr} + (AW+1)'(size_bytes(ld_size));
  assign ld_mis = is_misaligned(ld_addr[2:0], ld_size);

  // byte-range overlap per slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_ovl
    logic [AW:0] st_end;
    assign st_end = {1'b0, e_addr[g]} + (AW+1)'(size_bytes(e_size[g]));
    assign ovl[g] = e_vld[g] &&
                    ({1'b0, e_addr[g]} < ld_end) &&
                    ({1'b0, ld_addr} < st_end);
  end

  // age scan from the head: the last overlap seen is the youngest
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_idx + PTR_W'(k);
      if (ovl[idx]) begin
        hit = 1'b1;
        sel = idx;
      end
    end
  end

  assign ok = (e_addr[sel] == ld_addr) && (ld_size <= e_size[sel]) &&
              !ld_mis && !e_block[sel];

  always_comb begin
    m_data = '0;
    if (!hit) begin
      m_kind = RSP_MISS;
    end else if (ok) begin
      m_kind = RSP_FWD;
      m_data = e_data[sel] & low_mask(ld_size);
    end else begin
      m_kind = RSP_STALL;
    end
  end

endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer
  import sfb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enq_valid,
  input  logic [AW-1:0] enq_addr,
  input  logic [1:0]    enq_size,
  input  logic [63:0]   enq_data,
  input  logic          enq_hibyte,
  input  logic          enq_misflag,
  output logic          enq_full,
  input  logic          ret_strobe,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_size,
  output logic          rsp_valid,
  output logic [1:0]    rsp_kind,
  output logic [63:0]   rsp_data,
  output logic          cw_valid,
  output logic [AW-1:0] cw_addr,
  output logic [1:0]    cw_size,
  output logic [63:0]   cw_data
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0]         e_vld, e_block;
  logic [DEPTH-1:0][AW-1:0] e_addr;
  logic [DEPTH-1:0][1:0]    e_size;
  logic [DEPTH-1:0][DW-1:0] e_data;
  logic [PTR_W-1:0]         head_idx;
  rsp_kind_e                m_kind;
  logic [DW-1:0]            m_data;
  logic [1:0]               rsp_size_q;

  sfb_queue #(.DEPTH(DEPTH), .AW(AW)) u_queue (
    .clk(clk), .rst(rst),
    .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_size(enq_size),
    .enq_data(enq_data), .enq_hibyte(enq_hibyte), .enq_misflag(enq_misflag),
    .enq_full(enq_full), .ret_strobe(ret_strobe),
    .e_vld(e_vld), .e_addr(e_addr), .e_size(e_size), .e_data(e_data),
    .e_block(e_block), .head_idx(head_idx),
    .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_size(cw_size), .cw_data(cw_data)
  );

  sfb_match #(.DEPTH(DEPTH), .AW(AW)) u_match (
    .ld_addr(ld_addr), .ld_size(ld_size),
    .e_vld(e_vld), .e_addr(e_addr), .e_size(e_size), .e_data(e_data),
    .e_block(e_block), .head_idx(head_idx),
    .m_kind(m_kind), .m_data(m_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_kind   <= RSP_MISS;
      rsp_data   <= '0;
      rsp_size_q <= '0;
    end else begin
      rsp_valid  <= ld_valid;
      rsp_kind   <= ld_valid ? m_kind : RSP_MISS;
      rsp_data   <= ld_valid ? m_data : '0;
      rsp_size_q <= ld_size;
    end
  end

  // R5
  fwd_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == RSP_FWD) |-> ((rsp_data & ~low_mask(rsp_size_q)) == '0));

  // R4
  kind_legal_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_kind != 2'd3));

  // R4
  miss_no_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_kind != RSP_FWD) |-> (rsp_data == '0));

endmodule

// File: tb/tb_store_fwd_buffer.sv
module tb_store_fwd_buffer;

  localparam int AW = 16;

  logic clk = 0, rst = 1;
  logic enq_valid = 0, enq_hibyte = 0, enq_misflag = 0, ret_strobe = 0, ld_valid = 0;
  logic [AW-1:0] enq_addr = 0, ld_addr = 0;
  logic [1:0] enq_size = 0, ld_size = 0;
  logic [63:0] enq_data = 0;
  logic enq_full, rsp_valid, cw_valid;
  logic [1:0] rsp_kind, cw_size;
  logic [63:0] rsp_data, cw_data;
  logic [AW-1:0] cw_addr;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  store_fwd_buffer #(.DEPTH(8), .AW(AW)) dut (.*);

  // bench model of the queue, oldest at index 0
  int mq_n = 0;
  int mq_addr[8], mq_size[8], mq_hib[8], mq_mis[8];
  logic [63:0] mq_data[8];

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp, string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  function automatic void model(input int la, input int lsz, output int kind, output logic [63:0] d);
    int found = -1;
    int lb = 1 << lsz;
    kind = 0; d = 0;
    for (int i = 0; i < mq_n; i++) begin
      int sb = 1 << mq_size[i];
      if (mq_addr[i] < la + lb && la < mq_addr[i] + sb) found = i;
    end
    if (found >= 0) begin
      int sb = 1 << mq_size[found];
      bit smis = (mq_mis[found] != 0) || (mq_addr[found] % sb != 0);
      bit lmis = (la % lb) != 0;
      if (mq_addr[found] == la && lsz <= mq_size[found] && !smis && !lmis && mq_hib[found] == 0) begin
        kind = 1;
        d = (lsz == 3) ? mq_data[found] : (mq_data[found] & ((64'd1 << (8 * lb)) - 1));
      end else kind = 2;
    end
  endfunction

  task automatic enq(int a, int s, logic [63:0] d, int hib, int mis);
    @(negedge clk);
    enq_valid = 1; enq_addr = AW'(a); enq_size = 2'(s); enq_data = d;
    enq_hibyte = (hib != 0); enq_misflag = (mis != 0);
    @(negedge clk);
    enq_valid = 0; enq_hibyte = 0; enq_misflag = 0;
    if (mq_n < 8) begin
      mq_addr[mq_n] = a; mq_size[mq_n] = s; mq_data[mq_n] = d;
      mq_hib[mq_n] = hib; mq_mis[mq_n] = mis; mq_n++;
    end
  endtask

  task automatic load(int la, int lsz, string req);
    int k; logic [63:0] d;
    model(la, lsz, k, d);
    @(negedge clk);
    ld_valid = 1; ld_addr = AW'(la); ld_size = 2'(lsz);
    @(negedge clk);
    ld_valid = 0;
    chk(req, 64'(rsp_valid), 64'd1, "rsp_valid");
    chk(req, 64'(rsp_kind), 64'(k), $sformatf("kind a=%h s=%0d", la, lsz));
    chk(req, rsp_data, d, $sformatf("data a=%h s=%0d", la, lsz));
  endtask

  // retire one store; expect its drain exactly two edges after the pulse
  task automatic retire_one(string req);
    @(negedge clk);
    ret_strobe = 1;
    @(negedge clk);
    ret_strobe = 0;
    chk(req, 64'(cw_valid), 64'd0, "cw_valid early");
    @(negedge clk);
    if (mq_n > 0) begin
      chk(req, 64'(cw_valid), 64'd1, "cw_valid");
      chk(req, 64'(cw_addr), 64'(mq_addr[0]), "cw_addr");
      chk(req, 64'(cw_size), 64'(mq_size[0]), "cw_size");
      chk(req, cw_data, mq_data[0], "cw_data");
      for (int i = 0; i < 7; i++) begin
        mq_addr[i] = mq_addr[i+1]; mq_size[i] = mq_size[i+1]; mq_data[i] = mq_data[i+1];
        mq_hib[i] = mq_hib[i+1]; mq_mis[i] = mq_mis[i+1];
      end
      mq_n--;
    end else begin
      chk(req, 64'(cw_valid), 64'd0, "cw_valid with empty queue");
    end
  endtask

  initial begin
    #1200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk("R9", 64'(enq_full), 0, "enq_full");
    chk("R9", 64'(rsp_valid), 0, "rsp_valid");
    chk("R9", 64'(cw_valid), 0, "cw_valid");

    // R4 R5 R7 R8: sweep loads around one store per size and flag setting
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 3; v++) begin
        enq('h40, s, 64'h8877_6655_4433_2211 ^ (64'(s * 3 + v) << 60), (v == 1), (v == 2));
        for (int la = 'h38; la < 'h50; la++)
          for (int lsz = 0; lsz < 4; lsz++)
            load(la, lsz, "R5_R7_R8");
        retire_one("R3");
        load('h40, 0, "R7_release");
      end
    end

    // R8: misaligned by address alone
    enq('h41, 1, 64'hABCD, 0, 0);
    load('h41, 0, "R8");
    retire_one("R3");

    // R6: youngest of several overlapping stores decides
    enq('h40, 3, 64'h1111_1111_1111_1111, 0, 0);
    enq('h40, 3, 64'h2222_2222_2222_2222, 0, 0);
    load('h40, 3, "R6");
    enq('h44, 0, 64'h5A, 0, 0);
    load('h40, 3, "R6_R7");
    load('h44, 0, "R6");
    load('h48, 0, "R4");
    for (int i = 0; i < 3; i++) retire_one("R3");
    load('h40, 3, "R7_release");

    // R2: retire pulse with nothing to retire is ignored
    retire_one("R2");
    enq('h60, 2, 64'hCAFE_F00D, 0, 0);
    repeat (4) begin
      @(negedge clk);
      chk("R2", 64'(cw_valid), 0, "unretired drained");
    end
    load('h60, 2, "R2");
    retire_one("R3");

    // R1: fill to capacity, ninth store dropped
    for (int i = 0; i < 9; i++) begin
      enq('h80 + 8 * i, 3, 64'(i + 1), 0, 0);
      if (i == 6) chk("R1", 64'(enq_full), 0, "full at 7");
      if (i == 7) chk("R1", 64'(enq_full), 1, "full at 8");
    end
    load('h80 + 64, 3, "R1");
    load('h80 + 56, 3, "R1");
    for (int i = 0; i < 9; i++) retire_one("R1_R3");
    chk("R1", 64'(enq_full), 0, "full after drain");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule